// File: doc/BRIEF.md
# Pulsed Overload Protection Timer

This block decides, every clock cycle, whether the power stage of a supply regulator may conduct. It watches a synchronized overload indication from an external current clamp and two thermal comparator outputs, one asserted above the shutdown temperature and one asserted below the recovery temperature. It reports two sticky status flags, one for overload and one for over-temperature.

Two overload policies are selectable at run time. In static mode the external clamp limits the current, the stage stays on, and the overload flag mirrors the overload input one cycle late. In pulsed mode an overload switches the stage off for a long interval, then allows a retry window one tenth as long. Any overload inside the retry starts the cycle again. Only a retry window that completes with no overload returns the block to normal operation and clears the flag. Thermal shutdown overrides both policies and uses the two comparators to give hysteresis. Both window lengths are counted in clock cycles, so a bench can run scaled-down values.

Top module: `overload_guard`

## Requirements
- R1: After reset both status flags read 0, and with enable high and no fault the stage enable output is 1.
- R2: While the enable input is 0 the stage enable output is 0 in the same cycle, whatever the protection state.
- R3: In pulsed mode (static_mode_i = 0), the first clock edge that samples overload_i = 1 during normal operation drives the stage enable low and sets the overload flag. The stage then stays off for exactly OFF_CYCLES clock cycles, and overload_i is ignored during that time.
- R4: After the off interval the stage enable returns to 1 for a retry window of OFF_CYCLES/RATIO cycles. RATIO defaults to 10.
- R5: If the retry window completes with no overload sampled, the overload flag clears on the last edge of the window and not earlier.
- R6: An overload sampled during the retry window ends the window and starts a new off interval on that edge, with the flag still set.
- R7: In static mode (static_mode_i = 1) the stage enable is not affected by overload, and the overload flag equals the value of overload_i sampled on the previous edge.
- R8: Setting static mode during a pulsed off interval abandons the interval on the next edge. The stage enable returns to 1 and the flag follows the overload input.
- R9: temp_hot_i = 1 sets the over-temperature flag on the next edge and forces the stage enable to 0. The flag holds while both comparators are 0 and clears only on an edge that samples temp_cool_i = 1 with temp_hot_i = 0.
- R10: Dropping the enable input resets the retry timer but leaves both flags unchanged. On re-enable in pulsed mode with the overload flag set, a clean retry window is needed to clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| en_i | input | 1 | Power stage enable request |
| static_mode_i | input | 1 | 1 selects the static overload policy, 0 selects the pulsed policy |
| overload_i | input | 1 | Synchronized overload indication from the current clamp |
| temp_hot_i | input | 1 | Junction above the shutdown threshold |
| temp_cool_i | input | 1 | Junction below the recovery threshold |
| power_en_o | output | 1 | Stage may conduct |
| ovl_flag_o | output | 1 | Overload status flag |
| ovt_flag_o | output | 1 | Over-temperature status flag |

## Verification
An off-interval counter that is wrong by one shows up at the ports as a stage enable that comes back one cycle early or late. The checks therefore count the exact cycle in which power_en_o rises. A retry window that is too short or too long shows up at its last edge as an overload flag that clears in the wrong cycle. A sequencer stuck in a stale state after a mode change or an enable drop shows up within one edge, either as a stage that stays off or as a flag that never clears. A lost thermal hysteresis shows up as an over-temperature flag that clears while both comparators are low.

// File: rtl/ovg_pkg.sv
package ovg_pkg;
  typedef enum logic [1:0] {
    GS_RUN   = 2'd0,
    GS_OFF   = 2'd1,
    GS_RETRY = 2'd2
  } guard_state_e;
endpackage

// File: rtl/ovg_thermal.sv
module ovg_thermal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  output logic ovt_o
);
  logic ovt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ovt_q <= 1'b0;
    else if (temp_hot_i)  ovt_q <= 1'b1;
    else if (temp_cool_i) ovt_q <= 1'b0;
  end

  assign ovt_o = ovt_q;

  assert_hot_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_hot_i |=> ovt_o);
  assert_hysteresis_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovt_o && !temp_hot_i && !temp_cool_i) |=> ovt_o);
  assert_cool_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_cool_i && !temp_hot_i) |=> !ovt_o);
endmodule

// File: rtl/ovg_retry_seq.sv
module ovg_retry_seq
  import ovg_pkg::*;
#(
  parameter int unsigned OFF_CYCLES = 9_000_000,
  parameter int unsigned RATIO      = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic static_mode_i,
  input  logic overload_i,
  output logic hold_off_o,
  output logic olf_o
);
  localparam int unsigned ON_RAW     = OFF_CYCLES / RATIO;
  localparam int unsigned ON_CYCLES  = (ON_RAW == 0) ? 1 : ON_RAW;
  localparam int unsigned CW         = $clog2(OFF_CYCLES + 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYCLES - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYCLES - 1);

  guard_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic olf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GS_RUN;
      cnt_q   <= '0;
      olf_q   <= 1'b0;
    end else if (static_mode_i) begin
      // static policy: clamp is external, flag mirrors the input
      state_q <= GS_RUN;
      cnt_q   <= '0;
      olf_q   <= overload_i;
    end else if (!en_i) begin
      // timer cleared, flag retained
      state_q <= GS_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        GS_RUN: begin
          cnt_q <= '0;
          if (overload_i) begin
            state_q <= GS_OFF;
            olf_q   <= 1'b1;
          end else if (olf_q) begin
            state_q <= GS_RETRY;
          end
        end
        GS_OFF: begin
          if (cnt_q == OFF_LAST) begin
            state_q <= GS_RETRY;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        GS_RETRY: begin
          if (overload_i) begin
            state_q <= GS_OFF;
            cnt_q   <= '0;
          end else if (cnt_q == ON_LAST) begin
            state_q <= GS_RUN;
            cnt_q   <= '0;
            olf_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= GS_RUN;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign hold_off_o = (state_q == GS_OFF);
  assign olf_o      = olf_q;

  assert_off_flagged_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GS_OFF) |-> olf_q);
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GS_OFF) |-> (cnt_q <= OFF_LAST));
  assert_retry_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GS_RETRY) |-> (cnt_q <= ON_LAST));
  assert_retry_trip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GS_RETRY && overload_i && en_i && !static_mode_i)
      |=> (state_q == GS_OFF && olf_q));
  assert_static_mirror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    static_mode_i |=> (olf_q == $past(overload_i)));
  assert_static_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    static_mode_i |=> (state_q != GS_OFF));
  assert_en_keeps_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !static_mode_i) |=> (olf_q == $past(olf_q)));
endmodule

// File: rtl/overload_guard.sv
module overload_guard #(
  parameter int unsigned OFF_CYCLES = 9_000_000,
  parameter int unsigned RATIO      = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic static_mode_i,
  input  logic overload_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  output logic power_en_o,
  output logic ovl_flag_o,
  output logic ovt_flag_o
);
  logic hold_off;
  logic ovt;

  ovg_retry_seq #(
    .OFF_CYCLES (OFF_CYCLES),
    .RATIO      (RATIO)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .static_mode_i (static_mode_i),
    .overload_i    (overload_i),
    .hold_off_o    (hold_off),
    .olf_o         (ovl_flag_o)
  );

  ovg_thermal u_thermal (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .temp_hot_i  (temp_hot_i),
    .temp_cool_i (temp_cool_i),
    .ovt_o       (ovt)
  );

  assign ovt_flag_o = ovt;
  assign power_en_o = en_i && !ovt && !hold_off;

  assert_en_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !power_en_o);
  assert_thermal_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovt_flag_o |-> !power_en_o);
  assert_static_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (static_mode_i && $past(static_mode_i) && en_i && !ovt_flag_o) |-> power_en_o);
endmodule

// File: tb/overload_guard_tb.sv
module overload_guard_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  TOFF = 40;
  localparam int  TON  = TOFF / 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, stat = 1'b0, ovl = 1'b0, hot = 1'b0, cool = 1'b0;
  logic pwr, olf, otf;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  overload_guard #(.OFF_CYCLES(TOFF), .RATIO(10)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .static_mode_i(stat),
    .overload_i(ovl), .temp_hot_i(hot), .temp_cool_i(cool),
    .power_en_o(pwr), .ovl_flag_o(olf), .ovt_flag_o(otf)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one overload pulse in pulsed mode; leaves block in GS_OFF, cnt 0
  task automatic trip();
    ovl = 1'b1;
    step(1);
    ovl = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 olf", olf, 1'b0);
    chk("R1 otf", otf, 1'b0);
    chk("R2 pwr en low", pwr, 1'b0);
    en = 1'b1;
    #1;
    chk("R1 pwr", pwr, 1'b1);
  endtask

  task automatic t_pulsed();
    trip();
    chk("R3 pwr off", pwr, 1'b0);
    chk("R3 olf set", olf, 1'b1);
    ovl = 1'b1;             // ignored while off
    step(TOFF - 1);
    ovl = 1'b0;
    chk("R3 still off", pwr, 1'b0);
    step(1);
    chk("R4 retry on", pwr, 1'b1);
    chk("R4 olf held", olf, 1'b1);
    step(TON - 1);
    chk("R5 not early", olf, 1'b1);
    step(1);
    chk("R5 olf clear", olf, 1'b0);
    chk("R5 pwr", pwr, 1'b1);
  endtask

  task automatic t_repeat();
    ovl = 1'b1;
    step(1);
    step(TOFF);
    chk("R4 retry pwr", pwr, 1'b1);
    step(1);
    chk("R6 re-off", pwr, 1'b0);
    chk("R6 olf", olf, 1'b1);
    ovl = 1'b0;
    step(TOFF + TON);
    chk("R6 recover olf", olf, 1'b0);
    chk("R6 recover pwr", pwr, 1'b1);
  endtask

  task automatic t_static();
    stat = 1'b1;
    ovl = 1'b1;
    step(1);
    chk("R7 pwr stays", pwr, 1'b1);
    chk("R7 olf set", olf, 1'b1);
    step(5);
    chk("R7 pwr long", pwr, 1'b1);
    ovl = 1'b0;
    step(1);
    chk("R7 olf clear", olf, 1'b0);
    stat = 1'b0;
    step(1);
  endtask

  task automatic t_switch();
    trip();
    step(3);
    chk("R8 off before", pwr, 1'b0);
    stat = 1'b1;
    step(1);
    chk("R8 pwr back", pwr, 1'b1);
    chk("R8 olf follows", olf, 1'b0);
    stat = 1'b0;
    step(1);
    chk("R8 stays normal", pwr, 1'b1);
  endtask

  task automatic t_enable();
    trip();
    step(2);
    en = 1'b0;
    #1;
    chk("R2 pwr low", pwr, 1'b0);
    step(3);
    chk("R10 olf kept", olf, 1'b1);
    en = 1'b1;
    #1;
    chk("R10 pwr on", pwr, 1'b1);
    step(1);
    chk("R10 olf retry", olf, 1'b1);
    step(TON);
    chk("R10 olf clear", olf, 1'b0);
  endtask

  task automatic t_thermal();
    hot = 1'b1;
    step(1);
    chk("R9 otf set", otf, 1'b1);
    chk("R9 pwr off", pwr, 1'b0);
    hot = 1'b0;
    step(3);
    chk("R9 hyst hold", otf, 1'b1);
    en = 1'b0;
    step(2);
    en = 1'b1;
    step(1);
    chk("R10 otf kept", otf, 1'b1);
    chk("R9 pwr still off", pwr, 1'b0);
    cool = 1'b1;
    step(1);
    cool = 1'b0;
    chk("R9 otf clear", otf, 1'b0);
    chk("R9 pwr back", pwr, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 50_000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_pulsed();
    t_repeat();
    t_static();
    t_switch();
    t_enable();
    t_thermal();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule